// File: doc/BRIEF.md
# Interrupt Controller Command Register Interface

This block is the byte-wide programming front end of one eight-line interrupt controller. A host reaches it through a small access port with three addresses: a command port, a data port and a trigger-mode register. Command-port writes are classified into an initialization command, a read-control command or an operation command. The data port is steered by an initialization sequencer: while a sequence is in progress it delivers the vector base, the cascade word and the mode word; afterwards it loads the interrupt mask.

The block does no priority arithmetic. Decoded operations (end-of-interrupt, priority set, mask update, initialization and poll acknowledge) go out as one-cycle strobes with the line number they name, for a separate priority resolver. The resolver returns its request and in-service vectors and its highest pending line, which the block serves back on reads. Single mode and level-sensitive global mode are flagged as unsupported and have no other effect.

Every access is sampled on a rising clock edge. All strobes, read data and state outputs are registered and appear in the cycle that follows the access.

Top module: `pic_cmd_regif`

## Requirements
- R1: A byte write to the command port (address 0) with bit 4 set is an initialization command. In the next cycle `init_pulse` is high and `mask_out`, `vec_base`, `fully_nested`, `auto_eoi`, `rot_auto_eoi`, `spec_mask`, read select and poll arming are all zero. `trig_out` keeps its value.
- R2: In an initialization command, bit 1 set pulses `unsup_single` and bit 3 set pulses `unsup_level` together with `init_pulse`. Neither changes any other output.
- R3: After an initialization command, data-port (address 1) writes go to the sequence and not to the mask. The first write sets `vec_base` to the written byte AND 0xF8. A cascade word follows only if the command had bit 1 clear. A mode word follows only if the command had bit 0 set; it sets `fully_nested` from bit 4 and `auto_eoi` from bit 1. After the last expected word the block returns to normal operation.
- R4: A command-port write with bit 4 clear and bit 3 set is read control. Bit 2 arms a poll. Bit 1 set loads read select from bit 0 (1 = in-service, 0 = request). Bit 6 set loads `spec_mask` from bit 5.
- R5: A command-port write with bits 4 and 3 clear is an operation command with code in bits 7..5. Code 4 sets `rot_auto_eoi`, code 0 clears it, and code 2 changes nothing and raises no strobe.
- R6: Codes 1, 3, 5 and 7 pulse `eoi_pulse`. `eoi_specific` is set for codes 3 and 7, `eoi_rotate` is set for codes 5 and 7, and `cmd_line` is bits 2..0 of the write.
- R7: Code 6 pulses `prio_pulse` with `cmd_line` equal to bits 2..0 and does not pulse `eoi_pulse`.
- R8: In normal operation a data-port write sets `mask_out` to the written byte and pulses `mask_pulse` for one cycle. `mask_out` changes at no other time except initialization.
- R9: A byte read pulses `rd_valid` in the next cycle. When no poll is armed, `rd_data` is `req_in` or `svc_in` on the command port (per read select), `mask_out` on the data port, `trig_out` on address 2, and 0 on address 3.
- R10: The first command- or data-port read after a poll is armed disarms the poll. If `pend_valid` is high it returns `pend_line` zero-extended and pulses `poll_ack` with `poll_line` equal to that line. Otherwise it returns 0x07 with no acknowledge.
- R11: A write to address 2 sets `trig_out` to the byte AND `TRIG_WMASK` (default 0xF8). Writes to address 3 are ignored.
- R12: An access with `acc_size` other than 0 (byte) pulses `acc_err`. It produces no read data, no strobe and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access request, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 2 | 0 command, 1 data, 2 trigger mode, 3 unmapped |
| acc_size | input | 2 | Access size code, 0 = byte |
| acc_wdata | input | 8 | Write byte |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Read data valid |
| acc_err | output | 1 | Non-byte access rejected |
| req_in | input | 8 | Request vector from resolver |
| svc_in | input | 8 | In-service vector from resolver |
| pend_valid | input | 1 | Resolver has a pending line |
| pend_line | input | 3 | Highest pending line |
| mask_out | output | 8 | Interrupt mask |
| trig_out | output | 8 | Per-line trigger mode |
| vec_base | output | 8 | Vector base |
| fully_nested | output | 1 | Special fully nested mode |
| auto_eoi | output | 1 | Automatic end-of-interrupt |
| rot_auto_eoi | output | 1 | Rotate on automatic end-of-interrupt |
| spec_mask | output | 1 | Special mask mode |
| init_pulse | output | 1 | Reset resolver state and drop interrupt output |
| eoi_pulse | output | 1 | End-of-interrupt strobe |
| eoi_specific | output | 1 | End-of-interrupt names `cmd_line` |
| eoi_rotate | output | 1 | End-of-interrupt rotates priority |
| prio_pulse | output | 1 | Set lowest priority to `cmd_line` |
| cmd_line | output | 3 | Line named by the operation command |
| mask_pulse | output | 1 | Mask changed, re-evaluate output |
| poll_ack | output | 1 | Poll acknowledged a line |
| poll_line | output | 3 | Line acknowledged by poll |
| unsup_single | output | 1 | Single mode requested (unsupported) |
| unsup_level | output | 1 | Level-sensitive mode requested (unsupported) |

## Verification
The assertions assume one access per `acc_en` cycle, with `acc_addr`, `acc_size` and `acc_wdata` valid whenever `acc_en` is high. They also assume `acc_en` is low while reset is applied, because the properties look one cycle back at these inputs. The stimulus drives each access for exactly one cycle and then leaves an idle cycle. It holds `req_in`, `svc_in`, `pend_valid` and `pend_line` steady around every read, so the expected values pushed to the scoreboard match what the design samples.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int NLINES = 8;
  localparam int LINE_W = $clog2(NLINES);
  localparam logic [BYTE_W-1:0] VEC_MASK = 8'hF8;
  localparam logic [BYTE_W-1:0] POLL_IDLE = 8'h07;

  // command byte bit positions
  localparam int B_INIT   = 4;
  localparam int B_RDCTL  = 3;
  localparam int B_POLL   = 2;
  localparam int B_RSLD   = 1;
  localparam int B_RSVAL  = 0;
  localparam int B_SMLD   = 6;
  localparam int B_SMVAL  = 5;
  localparam int B_SINGLE = 1;
  localparam int B_LEVEL  = 3;
  localparam int B_NEED4  = 0;
  localparam int B_FNEST  = 4;
  localparam int B_AEOI   = 1;

  localparam logic [2:0] OP_ROT_CLR = 3'd0;
  localparam logic [2:0] OP_ROT_SET = 3'd4;
  localparam logic [2:0] OP_PRIO    = 3'd6;

  typedef enum logic [1:0] {
    SEQ_RUN = 2'd0,
    SEQ_W2  = 2'd1,
    SEQ_W3  = 2'd2,
    SEQ_W4  = 2'd3
  } seq_st_e;

  typedef enum logic [1:0] {
    PORT_CMD  = 2'd0,
    PORT_DATA = 2'd1,
    PORT_TRIG = 2'd2,
    PORT_NONE = 2'd3
  } port_e;

  typedef struct packed {
    logic              init;
    logic              rdctl;
    logic              op;
    logic              rot_set;
    logic              rot_clr;
    logic              eoi;
    logic              eoi_spec;
    logic              eoi_rot;
    logic              prio;
    logic              poll;
    logic              rsel_ld;
    logic              rsel_val;
    logic              smm_ld;
    logic              smm_val;
    logic              single;
    logic              level;
    logic              need3;
    logic              need4;
    logic [LINE_W-1:0] line;
  } cmd_dec_t;
endpackage

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
  import pic_cmd_pkg::*;
(
  input  logic [BYTE_W-1:0] cmd_byte,
  output cmd_dec_t          dec
);
  logic [2:0] code;

  always_comb begin
    code         = cmd_byte[7:5];
    dec.init     = cmd_byte[B_INIT];
    dec.rdctl    = !cmd_byte[B_INIT] && cmd_byte[B_RDCTL];
    dec.op       = !cmd_byte[B_INIT] && !cmd_byte[B_RDCTL];
    dec.rot_set  = (code == OP_ROT_SET);
    dec.rot_clr  = (code == OP_ROT_CLR);
    dec.eoi      = code[0];
    dec.eoi_spec = code[1];
    dec.eoi_rot  = code[2];
    dec.prio     = (code == OP_PRIO);
    dec.poll     = cmd_byte[B_POLL];
    dec.rsel_ld  = cmd_byte[B_RSLD];
    dec.rsel_val = cmd_byte[B_RSVAL];
    dec.smm_ld   = cmd_byte[B_SMLD];
    dec.smm_val  = cmd_byte[B_SMVAL];
    dec.single   = cmd_byte[B_SINGLE];
    dec.level    = cmd_byte[B_LEVEL];
    dec.need3    = !cmd_byte[B_SINGLE];
    dec.need4    = cmd_byte[B_NEED4];
    dec.line     = cmd_byte[LINE_W-1:0];
  end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              icw1_wr,
  input  logic              need3,
  input  logic              need4,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              in_init,
  output logic [BYTE_W-1:0] vec_base,
  output logic              fully_nested,
  output logic              auto_eoi
);
  seq_st_e           st_q, st_d;
  logic              n3_q, n3_d, n4_q, n4_d;
  logic [BYTE_W-1:0] vb_q, vb_d;
  logic              fn_q, fn_d, ae_q, ae_d;
  logic              seq_en;

  assign seq_en = icw1_wr || data_wr;

  always_comb begin
    st_d = st_q;
    n3_d = n3_q;
    n4_d = n4_q;
    vb_d = vb_q;
    fn_d = fn_q;
    ae_d = ae_q;
    if (icw1_wr) begin
      st_d = SEQ_W2;
      n3_d = need3;
      n4_d = need4;
      vb_d = '0;
      fn_d = 1'b0;
      ae_d = 1'b0;
    end else if (data_wr) begin
      case (st_q)
        SEQ_W2: begin
          vb_d = wdata & VEC_MASK;
          st_d = n3_q ? SEQ_W3 : (n4_q ? SEQ_W4 : SEQ_RUN);
        end
        SEQ_W3: st_d = n4_q ? SEQ_W4 : SEQ_RUN;
        SEQ_W4: begin
          fn_d = wdata[B_FNEST];
          ae_d = wdata[B_AEOI];
          st_d = SEQ_RUN;
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SEQ_RUN;
      n3_q <= 1'b0;
      n4_q <= 1'b0;
      vb_q <= '0;
      fn_q <= 1'b0;
      ae_q <= 1'b0;
    end else if (seq_en) begin
      st_q <= st_d;
      n3_q <= n3_d;
      n4_q <= n4_d;
      vb_q <= vb_d;
      fn_q <= fn_d;
      ae_q <= ae_d;
    end
  end

  assign in_init      = (st_q != SEQ_RUN);
  assign vec_base     = vb_q;
  assign fully_nested = fn_q;
  assign auto_eoi     = ae_q;

  // R3: the mode word always ends the sequence
  p_w4_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_W4 && data_wr && !icw1_wr) |=> (st_q == SEQ_RUN));
  // R3: the cascade word is only awaited when the command asked for it
  p_w3_only_if_needed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_W2 && data_wr && !icw1_wr && !n3_q) |=> (st_q != SEQ_W3));
  // R1: an initialization command always restarts at the vector word
  p_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    icw1_wr |=> (st_q == SEQ_W2 && !fn_q && !ae_q));
endmodule

// File: rtl/pic_read_path.sv
module pic_read_path
  import pic_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  port_e             port,
  input  logic              read_sel,
  input  logic              poll_armed,
  input  logic [BYTE_W-1:0] mask,
  input  logic [BYTE_W-1:0] trig,
  input  logic [BYTE_W-1:0] req_in,
  input  logic [BYTE_W-1:0] svc_in,
  input  logic              pend_valid,
  input  logic [LINE_W-1:0] pend_line,
  output logic              poll_take,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              poll_ack,
  output logic [LINE_W-1:0] poll_line
);
  logic [BYTE_W-1:0] data_d, data_q;
  logic              ack_d, ack_q, vld_q;
  logic [LINE_W-1:0] line_q;

  always_comb begin
    data_d    = '0;
    ack_d     = 1'b0;
    poll_take = rd_req && poll_armed && (port == PORT_CMD || port == PORT_DATA);
    if (poll_take) begin
      if (pend_valid) begin
        data_d = BYTE_W'(pend_line);
        ack_d  = 1'b1;
      end else begin
        data_d = POLL_IDLE;
      end
    end else begin
      case (port)
        PORT_CMD:  data_d = read_sel ? svc_in : req_in;
        PORT_DATA: data_d = mask;
        PORT_TRIG: data_d = trig;
        default:   data_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      vld_q <= rd_req;
      ack_q <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (rd_req) begin
      data_q <= data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
    end else if (ack_d) begin
      line_q <= pend_line;
    end
  end

  assign rd_data   = data_q;
  assign rd_valid  = vld_q;
  assign poll_ack  = ack_q;
  assign poll_line = line_q;

  // R10: an acknowledge only accompanies a read result
  p_ack_with_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    poll_ack |-> rd_valid);
  // R10: an empty poll answers with the idle code
  p_poll_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_take && !pend_valid) |=> (rd_valid && !poll_ack && rd_data == POLL_IDLE));
  // R10: the acknowledged line is echoed in the read byte
  p_poll_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
    poll_ack |-> (rd_data == BYTE_W'(poll_line)));
endmodule

// File: rtl/pic_cmd_regif.sv
module pic_cmd_regif
  import pic_cmd_pkg::*;
#(
  parameter logic [7:0] TRIG_WMASK = 8'hF8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_en,
  input  logic       acc_wr,
  input  logic [1:0] acc_addr,
  input  logic [1:0] acc_size,
  input  logic [7:0] acc_wdata,
  output logic [7:0] rd_data,
  output logic       rd_valid,
  output logic       acc_err,
  input  logic [7:0] req_in,
  input  logic [7:0] svc_in,
  input  logic       pend_valid,
  input  logic [2:0] pend_line,
  output logic [7:0] mask_out,
  output logic [7:0] trig_out,
  output logic [7:0] vec_base,
  output logic       fully_nested,
  output logic       auto_eoi,
  output logic       rot_auto_eoi,
  output logic       spec_mask,
  output logic       init_pulse,
  output logic       eoi_pulse,
  output logic       eoi_specific,
  output logic       eoi_rotate,
  output logic       prio_pulse,
  output logic [2:0] cmd_line,
  output logic       mask_pulse,
  output logic       poll_ack,
  output logic [2:0] poll_line,
  output logic       unsup_single,
  output logic       unsup_level
);
  cmd_dec_t dec;
  port_e    port;
  logic     acc_ok, wr, rd, cmd_wr, data_wr, trig_wr, icw1_wr, mask_wr;
  logic     in_init, poll_take;

  assign port    = port_e'(acc_addr);
  assign acc_ok  = acc_en && (acc_size == 2'd0);
  assign wr      = acc_ok && acc_wr;
  assign rd      = acc_ok && !acc_wr;
  assign cmd_wr  = wr && (port == PORT_CMD);
  assign data_wr = wr && (port == PORT_DATA);
  assign trig_wr = wr && (port == PORT_TRIG);
  assign icw1_wr = cmd_wr && dec.init;
  assign mask_wr = data_wr && !in_init;

  pic_cmd_decode u_decode (
    .cmd_byte (acc_wdata),
    .dec      (dec)
  );

  pic_init_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .icw1_wr      (icw1_wr),
    .need3        (dec.need3),
    .need4        (dec.need4),
    .data_wr      (data_wr),
    .wdata        (acc_wdata),
    .in_init      (in_init),
    .vec_base     (vec_base),
    .fully_nested (fully_nested),
    .auto_eoi     (auto_eoi)
  );

  // mode and mask state
  logic [BYTE_W-1:0] mask_q, mask_d, trig_q, trig_d;
  logic              rsel_q, rsel_d, poll_q, poll_d, smm_q, smm_d, rot_q, rot_d;
  logic              mode_en;

  assign mode_en = wr || poll_take;

  always_comb begin
    mask_d = mask_q;
    trig_d = trig_q;
    rsel_d = rsel_q;
    poll_d = poll_q;
    smm_d  = smm_q;
    rot_d  = rot_q;
    if (icw1_wr) begin
      mask_d = '0;
      rsel_d = 1'b0;
      poll_d = 1'b0;
      smm_d  = 1'b0;
      rot_d  = 1'b0;
    end else begin
      if (mask_wr) mask_d = acc_wdata;
      if (cmd_wr && dec.rdctl) begin
        if (dec.poll)    poll_d = 1'b1;
        if (dec.rsel_ld) rsel_d = dec.rsel_val;
        if (dec.smm_ld)  smm_d  = dec.smm_val;
      end
      if (cmd_wr && dec.op && dec.rot_set) rot_d = 1'b1;
      if (cmd_wr && dec.op && dec.rot_clr) rot_d = 1'b0;
      if (poll_take) poll_d = 1'b0;
    end
    if (trig_wr) trig_d = acc_wdata & TRIG_WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      trig_q <= '0;
      rsel_q <= 1'b0;
      poll_q <= 1'b0;
      smm_q  <= 1'b0;
      rot_q  <= 1'b0;
    end else if (mode_en) begin
      mask_q <= mask_d;
      trig_q <= trig_d;
      rsel_q <= rsel_d;
      poll_q <= poll_d;
      smm_q  <= smm_d;
      rot_q  <= rot_d;
    end
  end

  // command strobes toward the resolver
  logic init_d, eoi_d, prio_d, mpulse_d, single_d, level_d, err_d;
  logic init_q, eoi_q, espec_q, erot_q, prio_q, mpulse_q, single_q, level_q, err_q;
  logic [LINE_W-1:0] line_q;

  always_comb begin
    init_d   = icw1_wr;
    eoi_d    = cmd_wr && dec.op && dec.eoi;
    prio_d   = cmd_wr && dec.op && dec.prio;
    mpulse_d = mask_wr;
    single_d = icw1_wr && dec.single;
    level_d  = icw1_wr && dec.level;
    err_d    = acc_en && (acc_size != 2'd0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q   <= 1'b0;
      eoi_q    <= 1'b0;
      espec_q  <= 1'b0;
      erot_q   <= 1'b0;
      prio_q   <= 1'b0;
      mpulse_q <= 1'b0;
      single_q <= 1'b0;
      level_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      init_q   <= init_d;
      eoi_q    <= eoi_d;
      espec_q  <= eoi_d && dec.eoi_spec;
      erot_q   <= eoi_d && dec.eoi_rot;
      prio_q   <= prio_d;
      mpulse_q <= mpulse_d;
      single_q <= single_d;
      level_q  <= level_d;
      err_q    <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
    end else if (eoi_d || prio_d) begin
      line_q <= dec.line;
    end
  end

  pic_read_path u_read (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd),
    .port       (port),
    .read_sel   (rsel_q),
    .poll_armed (poll_q),
    .mask       (mask_q),
    .trig       (trig_q),
    .req_in     (req_in),
    .svc_in     (svc_in),
    .pend_valid (pend_valid),
    .pend_line  (pend_line),
    .poll_take  (poll_take),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .poll_ack   (poll_ack),
    .poll_line  (poll_line)
  );

  assign mask_out     = mask_q;
  assign trig_out     = trig_q;
  assign rot_auto_eoi = rot_q;
  assign spec_mask    = smm_q;
  assign init_pulse   = init_q;
  assign eoi_pulse    = eoi_q;
  assign eoi_specific = espec_q;
  assign eoi_rotate   = erot_q;
  assign prio_pulse   = prio_q;
  assign cmd_line     = line_q;
  assign mask_pulse   = mpulse_q;
  assign unsup_single = single_q;
  assign unsup_level  = level_q;
  assign acc_err      = err_q;

  // R1: initialization command clears mask and mode flags
  p_init_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && acc_size == 2'd0 && acc_addr == 2'd0 && acc_wdata[4])
      |=> (init_pulse && mask_out == '0 && !spec_mask && !rot_auto_eoi));
  // R8: the mask only moves with a mask strobe or an initialization
  p_mask_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_out != $past(mask_out)) |-> (mask_pulse || init_pulse));
  // R6: an end-of-interrupt strobe follows a command-port write
  p_eoi_from_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_pulse |-> $past(acc_en && acc_wr && acc_addr == 2'd0));
  // R7: a priority strobe is never an end-of-interrupt
  p_prio_not_eoi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prio_pulse |-> !eoi_pulse);
  // R2: unsupported-mode flags come only with an initialization
  p_unsup_with_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (unsup_single || unsup_level) |-> init_pulse);
  // R12: a rejected access has no visible effect
  p_err_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> (!rd_valid && !mask_pulse && !init_pulse && !eoi_pulse && !prio_pulse));
  // R11: trigger register only changes on a write to its address
  p_trig_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && acc_wr && acc_addr == 2'd2) |=> $stable(trig_out));
endmodule

// File: tb/test_pic_cmd_regif.sv
module test_pic_cmd_regif;
  logic       clk, rst_n;
  logic       acc_en, acc_wr;
  logic [1:0] acc_addr, acc_size;
  logic [7:0] acc_wdata;
  logic [7:0] rd_data;
  logic       rd_valid, acc_err;
  logic [7:0] req_in, svc_in;
  logic       pend_valid;
  logic [2:0] pend_line;
  logic [7:0] mask_out, trig_out, vec_base;
  logic       fully_nested, auto_eoi, rot_auto_eoi, spec_mask;
  logic       init_pulse, eoi_pulse, eoi_specific, eoi_rotate, prio_pulse;
  logic [2:0] cmd_line;
  logic       mask_pulse, poll_ack;
  logic [2:0] poll_line;
  logic       unsup_single, unsup_level;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 0;

  pic_cmd_regif i_pic_cmd_regif (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .acc_err(acc_err),
    .req_in(req_in), .svc_in(svc_in), .pend_valid(pend_valid),
    .pend_line(pend_line), .mask_out(mask_out), .trig_out(trig_out),
    .vec_base(vec_base), .fully_nested(fully_nested), .auto_eoi(auto_eoi),
    .rot_auto_eoi(rot_auto_eoi), .spec_mask(spec_mask),
    .init_pulse(init_pulse), .eoi_pulse(eoi_pulse),
    .eoi_specific(eoi_specific), .eoi_rotate(eoi_rotate),
    .prio_pulse(prio_pulse), .cmd_line(cmd_line), .mask_pulse(mask_pulse),
    .poll_ack(poll_ack), .poll_line(poll_line),
    .unsup_single(unsup_single), .unsup_level(unsup_level)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access, held for one cycle; returns at the negedge after the edge
  task automatic bus(input logic wr, input logic [1:0] addr,
                     input logic [1:0] sz, input logic [7:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = wr; acc_addr = addr; acc_size = sz; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0;
  endtask

  task automatic wr8(input logic [1:0] addr, input logic [7:0] d);
    bus(1'b1, addr, 2'd0, d);
  endtask

  task automatic rd8(input logic [1:0] addr, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus(1'b0, addr, 2'd0, 8'h00);
  endtask

  // monitor: pops expected read bytes as the design returns them
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected read actual=%h expected=none", rd_data);
      end else begin
        chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; acc_en = 1'b0; acc_wr = 1'b0; acc_addr = 2'd0;
    acc_size = 2'd0; acc_wdata = 8'h00;
    req_in = 8'h9C; svc_in = 8'h21; pend_valid = 1'b0; pend_line = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R1)
    chk("R1 reset mask", mask_out, 8'h00);
    chk("R1 reset trig", trig_out, 8'h00);
    chk("R1 reset flags", {4'b0, fully_nested, auto_eoi, rot_auto_eoi, spec_mask}, 8'h00);
    chk("R1 reset strobes", {init_pulse, eoi_pulse, prio_pulse, mask_pulse,
                             poll_ack, rd_valid, acc_err, unsup_single}, 8'h00);

    // trigger register (R11)
    wr8(2'd2, 8'hFF);
    chk("R11 trig masked", trig_out, 8'hF8);
    rd8(2'd2, 8'hF8, "R11 trig read");
    wr8(2'd3, 8'hFF);
    rd8(2'd3, 8'h00, "R11 unmapped read");

    // full init with cascade and mode words (R3)
    wr8(2'd0, 8'h11);
    chk("R1 init pulse", {init_pulse, unsup_single, unsup_level}, 3'b100);
    wr8(2'd1, 8'h2B);
    chk("R3 vector base", vec_base, 8'h28);
    chk("R3 mask untouched w2", {mask_out[7:1], mask_pulse}, 8'h00);
    wr8(2'd1, 8'h04);
    chk("R3 cascade word", {vec_base[7:1], mask_pulse}, {7'h14, 1'b0});
    chk("R3 mask untouched w3", mask_out, 8'h00);
    wr8(2'd1, 8'h12);
    chk("R3 mode word", {fully_nested, auto_eoi, mask_pulse}, 3'b110);
    wr8(2'd1, 8'hA5);
    chk("R8 mask load", mask_out, 8'hA5);
    chk("R8 mask pulse", {7'b0, mask_pulse}, 8'h01);
    rd8(2'd1, 8'hA5, "R9 data read mask");

    // init in single mode: third word skipped (R2, R3)
    wr8(2'd0, 8'h13);
    chk("R2 single flag", {init_pulse, unsup_single, unsup_level}, 3'b110);
    chk("R1 init clears", {mask_out[6:0], fully_nested}, 8'h00);
    chk("R1 auto eoi cleared", {7'b0, auto_eoi}, 8'h00);
    chk("R11 trig kept", trig_out, 8'hF8);
    wr8(2'd1, 8'h40);
    chk("R3 vector base 2", vec_base, 8'h40);
    wr8(2'd1, 8'h02);
    chk("R3 skip to mode word", {fully_nested, auto_eoi}, 2'b01);
    chk("R3 mask still clear", mask_out, 8'h00);
    wr8(2'd1, 8'h3C);
    chk("R3 back to run", mask_out, 8'h3C);

    // init with level bit, no mode word (R2, R3)
    wr8(2'd0, 8'h18);
    chk("R2 level flag", {init_pulse, unsup_single, unsup_level}, 3'b101);
    wr8(2'd1, 8'h0F);
    chk("R3 vector base 3", vec_base, 8'h08);
    wr8(2'd1, 8'h00);
    chk("R3 cascade no mask", {mask_out, 7'b0, mask_pulse}, 16'h0000);
    wr8(2'd1, 8'h55);
    chk("R3 no mode word", mask_out, 8'h55);
    chk("R3 auto eoi untouched", {7'b0, auto_eoi}, 8'h00);

    // read control (R4, R9)
    rd8(2'd0, 8'h9C, "R9 request read");
    wr8(2'd0, 8'h0B);
    rd8(2'd0, 8'h21, "R4 in-service select");
    wr8(2'd0, 8'h08);
    rd8(2'd0, 8'h21, "R4 select held");
    wr8(2'd0, 8'h0A);
    rd8(2'd0, 8'h9C, "R4 request select");
    wr8(2'd0, 8'h68);
    chk("R4 special mask on", {7'b0, spec_mask}, 8'h01);
    wr8(2'd0, 8'h28);
    chk("R4 special mask held", {7'b0, spec_mask}, 8'h01);
    wr8(2'd0, 8'h48);
    chk("R4 special mask off", {7'b0, spec_mask}, 8'h00);

    // operation commands (R5, R6, R7)
    wr8(2'd0, 8'h80);
    chk("R5 rotate set", {7'b0, rot_auto_eoi}, 8'h01);
    wr8(2'd0, 8'h47);
    chk("R5 nop", {rot_auto_eoi, eoi_pulse, prio_pulse, mask_pulse}, 4'b1000);
    wr8(2'd0, 8'h00);
    chk("R5 rotate clear", {7'b0, rot_auto_eoi}, 8'h00);
    wr8(2'd0, 8'h20);
    chk("R6 nonspecific", {eoi_pulse, eoi_specific, eoi_rotate, prio_pulse}, 4'b1000);
    wr8(2'd0, 8'h65);
    chk("R6 specific", {eoi_pulse, eoi_specific, eoi_rotate, prio_pulse, 1'b0, cmd_line}, 8'hC5);
    wr8(2'd0, 8'hA0);
    chk("R6 nonspecific rotate", {eoi_pulse, eoi_specific, eoi_rotate}, 3'b101);
    wr8(2'd0, 8'hE3);
    chk("R6 specific rotate", {eoi_pulse, eoi_specific, eoi_rotate, 2'b0, cmd_line}, 8'hE3);
    wr8(2'd0, 8'hC6);
    chk("R7 priority", {eoi_pulse, prio_pulse, 3'b0, cmd_line}, 8'h46);

    // poll (R10)
    pend_valid = 1'b1; pend_line = 3'd5;
    wr8(2'd0, 8'h0C);
    rd8(2'd1, 8'h05, "R10 poll line");
    chk("R10 poll ack", {poll_ack, 4'b0, poll_line}, 8'h85);
    rd8(2'd0, 8'h9C, "R10 poll disarmed");
    chk("R10 no second ack", {7'b0, poll_ack}, 8'h00);
    pend_valid = 1'b0;
    wr8(2'd0, 8'h0C);
    rd8(2'd0, 8'h07, "R10 poll empty");
    chk("R10 empty no ack", {7'b0, poll_ack}, 8'h00);

    // non-byte accesses (R12)
    bus(1'b1, 2'd1, 2'd1, 8'hFF);
    chk("R12 write rejected", {7'b0, acc_err}, 8'h01);
    chk("R12 mask kept", mask_out, 8'h55);
    bus(1'b1, 2'd0, 2'd2, 8'h11);
    chk("R12 init rejected", {acc_err, init_pulse}, 2'b10);
    bus(1'b0, 2'd1, 2'd1, 8'h00);
    chk("R12 read rejected", {acc_err, rd_valid}, 2'b10);
    rd8(2'd1, 8'h55, "R12 state intact");

    @(negedge clk);
    @(negedge clk);
    chk("R9 scoreboard drained", 8'(exp_q.size()), 8'h00);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule